// File: doc/BRIEF.md
# Process Channel Trip Evaluator

The block keeps a configuration word and two analog limits for each process channel and each test instance of that channel. Software picks a channel with a pointer register, then writes or reads that channel's configuration and limits through one register port. A second pointer-formatted input names the channel to test. When a test trigger arrives, the block compares the presented sample with the channel's limits, or with the expected level for a digital channel. It then applies the channel's gating conditions and reports a one-cycle trip result one clock later.

Channels below `ANALOG_CH` are analog; the rest up to `NUM_CH` are digital. A pointer value carries the channel number in its low byte and the instance number in its high byte. The block also drives a permit line. The line stays low until enough configuration writes have been accepted to cover the programmed active-channel count, and while any of the four presence inputs (two timing clocks, the data stream, the heartbeat) is low. Otherwise the line is high, and it drops for a fixed number of cycles each time a channel trips.

Top module: `pc_trip_eval`

## Requirements
- R1: After reset, `permit`, `trip_valid` and `trip` are 0, and every readback selection (0 pointer, 1 configuration, 2 low limit, 3 high limit, 4 active count, 5 intensity threshold) returns 0.
- R2: A write with `wr_sel`=0 loads the pointer whatever `cfg_enable` is. The pointer's low byte is the channel and its high byte the instance, and each (instance, channel) pair in range has its own storage. Readback 1..3 returns the pointed channel's stored word.
- R3: While `cfg_enable` is 0, writes with `wr_sel` 1 (configuration), 2 (low limit), 3 (high limit), 4 (active count) and 5 (threshold) change nothing, and a refused configuration write is not counted.
- R4: A write to the active count is accepted only when its value lies in 1..`NUM_CH`*`NUM_INST`; other values leave the count unchanged.
- R5: `permit` is 0 while the active count is 0 or the number of accepted configuration writes since reset is below the active count.
- R6: `permit` is 0 whenever any of `tclk_ok`, `bsync_ok`, `mdat_ok`, `heartbeat_ok` is 0. Once R5 and R6 are met and no trip pulse is running, `permit` is 1.
- R7: A cycle with `trig_valid`=1 gives, in the next cycle, `trip_valid`=1, `trip_ptr` equal to the triggering pointer, and `trip` equal to the evaluated result.
- R8: A channel whose configuration bit 15 is 0 never trips. A pointer whose channel is at least `NUM_CH` or whose instance is at least `NUM_INST` never trips, reads back 0 for selections 1..3, and accepts no configuration or limit write.
- R9: Configuration bits 11, 10 and 9, when set, allow a trip only while `ext_permit_a`, `ext_permit_b` and `beam_present` respectively are 1.
- R10: For a digital channel, the channel trips when `sample[0]` differs from configuration bit 8.
- R11: For an analog channel with bits 4 and 3 clear, the low check is enabled by bit 7 or bit 5 and trips when `sample` < low limit. The high check is enabled by bit 6 or bit 5 and trips when `sample` > high limit. The comparisons are unsigned 16-bit and equality does not trip.
- R12: Beam is high intensity when `intensity` >= the threshold register. With bit 4 set, the low check becomes `sample` > low limit and applies only at low intensity. With bit 3 set, the high check applies only at high intensity.
- R13: A trip drives `permit` to 0 for exactly `PULSE_LEN` cycles starting the cycle after the trigger. A new trip during the pulse restarts the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | 1 allows writes other than the pointer |
| wr_valid | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for write (0..5 as in R1) |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for readback |
| rd_data | output | 16 | Readback data (combinational) |
| trig_valid | input | 1 | Test trigger for `trig_ptr` |
| trig_ptr | input | 16 | Channel and instance to test, pointer format |
| sample | input | 16 | Sampled value (bit 0 for digital channels) |
| intensity | input | 16 | Current beam intensity |
| ext_permit_a | input | 1 | First external permit |
| ext_permit_b | input | 1 | Second external permit |
| beam_present | input | 1 | Beam is present |
| tclk_ok | input | 1 | First timing clock present |
| bsync_ok | input | 1 | Second timing clock present |
| mdat_ok | input | 1 | Data stream present |
| heartbeat_ok | input | 1 | Heartbeat present |
| trip_valid | output | 1 | Test result valid |
| trip | output | 1 | Tested channel tripped |
| trip_ptr | output | 16 | Pointer of the tested channel |
| permit | output | 1 | Permit output |

## Verification
The bench builds the block with 6 channels, 4 of them analog, and 2 instances, so the active count tops out at 12. That makes the count boundary at 12 and 13 easy to reach, and out-of-range pointers sit just past channel 5 and instance 1. In this small set-up every combination of the five analog limit-mode bits is swept against samples on and just past both limits, at intensities on either side of the threshold. All 64 combinations of the three gate bits and the three gate inputs are also covered. The permit pulse keeps its full 16-cycle length, so its exact width and its restart are checked cycle by cycle.

// File: rtl/pc_trip_pkg.sv
// Package: shared register selects, configuration bit positions and the
// per-channel record used by the trip evaluator.
package pc_trip_pkg;

    typedef enum logic [2:0] {
        SEL_POINTER = 3'd0,
        SEL_CONFIG  = 3'd1,
        SEL_LO_LIM  = 3'd2,
        SEL_HI_LIM  = 3'd3,
        SEL_COUNT   = 3'd4,
        SEL_THRESH  = 3'd5
    } reg_sel_e;

    localparam int BIT_ACTIVE      = 15;
    localparam int BIT_NEED_EXT_A  = 11;
    localparam int BIT_NEED_EXT_B  = 10;
    localparam int BIT_NEED_BEAM   = 9;
    localparam int BIT_DIG_LEVEL   = 8;
    localparam int BIT_LO_EN       = 7;
    localparam int BIT_HI_EN       = 6;
    localparam int BIT_BOTH_EN     = 5;
    localparam int BIT_LO_AS_UPPER = 4;
    localparam int BIT_HI_AS_UPPER = 3;

    typedef struct packed {
        logic [15:0] cfg;
        logic [15:0] lo;
        logic [15:0] hi;
    } chan_rec_t;

endpackage

// File: rtl/pc_cfg_store.sv
// Module: pc_cfg_store
// Holds the channel pointer, one record per (instance, channel), the active
// channel count, the intensity threshold and the accepted-config counter.
// Assumes pointer format {instance[15:8], channel[7:0]}; out-of-range
// pointers are neither written nor read.
module pc_cfg_store
    import pc_trip_pkg::*;
#(
    parameter int NUM_CH    = 96,
    parameter int ANALOG_CH = 64,
    parameter int NUM_INST  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_enable,
    input  logic        wr_valid,
    input  logic [2:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [15:0] rd_data,
    input  logic [15:0] trig_ptr,
    output chan_rec_t   trig_rec,
    output logic        trig_in_range,
    output logic        trig_is_analog,
    output logic [15:0] threshold,
    output logic        configured
);
    localparam int TOTAL = NUM_CH * NUM_INST;
    localparam int IDX_W = $clog2(TOTAL);
    localparam logic [7:0]       CH_LIM   = 8'(NUM_CH);
    localparam logic [7:0]       INST_LIM = 8'(NUM_INST);
    localparam logic [7:0]       ANA_LIM  = 8'(ANALOG_CH);
    localparam logic [15:0]      TOTAL_W  = 16'(TOTAL);
    localparam logic [IDX_W-1:0] NCH_W    = IDX_W'(NUM_CH);

    chan_rec_t      mem [TOTAL];
    logic [15:0]    pointer;
    logic [15:0]    ch_count;
    logic [15:0]    cfg_writes;
    logic           ptr_in, wr_ok, cfg_accept;
    logic [IDX_W-1:0] ptr_idx, trig_idx;

    function automatic logic in_range(input logic [15:0] p);
        return (p[7:0] < CH_LIM) && (p[15:8] < INST_LIM);
    endfunction

    function automatic logic [IDX_W-1:0] idx_of(input logic [15:0] p);
        return IDX_W'(p[15:8]) * NCH_W + IDX_W'(p[7:0]);
    endfunction

    // Decode the pointer and trigger addresses into safe record indices.
    always_comb begin
        ptr_in         = in_range(pointer);
        ptr_idx        = ptr_in ? idx_of(pointer) : '0;
        trig_in_range  = in_range(trig_ptr);
        trig_idx       = trig_in_range ? idx_of(trig_ptr) : '0;
        trig_is_analog = trig_ptr[7:0] < ANA_LIM;
        trig_rec       = mem[trig_idx];
        wr_ok          = wr_valid && cfg_enable;
        cfg_accept     = wr_ok && ptr_in && (wr_sel == SEL_CONFIG);
        configured     = (ch_count != 16'd0) && (cfg_writes >= ch_count);
    end

    // Pointer register: always writable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   pointer <= '0;
        else if (wr_valid && wr_sel == SEL_POINTER)   pointer <= wr_data;
    end

    // Per-channel records: written only when enabled and pointer in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem[i] <= '0;
        end else if (wr_ok && ptr_in) begin
            case (wr_sel)
                SEL_CONFIG: mem[ptr_idx].cfg <= wr_data;
                SEL_LO_LIM: mem[ptr_idx].lo  <= wr_data;
                SEL_HI_LIM: mem[ptr_idx].hi  <= wr_data;
                default:    ;
            endcase
        end
    end

    // Active count (range-checked) and intensity threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_count  <= '0;
            threshold <= '0;
        end else if (wr_ok) begin
            if (wr_sel == SEL_COUNT && wr_data != 16'd0 && wr_data <= TOTAL_W)
                ch_count <= wr_data;
            if (wr_sel == SEL_THRESH)
                threshold <= wr_data;
        end
    end

    // Saturating count of accepted configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cfg_writes <= '0;
        else if (cfg_accept && cfg_writes != 16'hFFFF) cfg_writes <= cfg_writes + 16'd1;
    end

    // Readback multiplexer.
    always_comb begin
        case (rd_sel)
            SEL_POINTER: rd_data = pointer;
            SEL_CONFIG:  rd_data = ptr_in ? mem[ptr_idx].cfg : 16'd0;
            SEL_LO_LIM:  rd_data = ptr_in ? mem[ptr_idx].lo  : 16'd0;
            SEL_HI_LIM:  rd_data = ptr_in ? mem[ptr_idx].hi  : 16'd0;
            SEL_COUNT:   rd_data = ch_count;
            SEL_THRESH:  rd_data = threshold;
            default:     rd_data = 16'd0;
        endcase
    end

    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ch_count <= TOTAL_W);

    assert_locked_regs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !cfg_enable) |=> ($stable(ch_count) && $stable(threshold) && $stable(cfg_writes)));

endmodule

// File: rtl/pc_limit_eval.sv
// Module: pc_limit_eval
// Combinational trip decision for one triggered channel: limit or level
// check, then mask and gate conditions. Assumes the record matches trig_ptr.
module pc_limit_eval
    import pc_trip_pkg::*;
(
    input  chan_rec_t   rec,
    input  logic        in_range,
    input  logic        is_analog,
    input  logic [15:0] sample,
    input  logic [15:0] intensity,
    input  logic [15:0] threshold,
    input  logic        ext_permit_a,
    input  logic        ext_permit_b,
    input  logic        beam_present,
    output logic        trip_now
);
    logic hi_int, lo_chk, hi_chk, lo_bad, hi_bad, limit_bad, gate_ok;
    logic unused_cfg_bits;

    assign unused_cfg_bits = ^{rec.cfg[14:12], rec.cfg[2:0]};

    // Evaluate limits, digital level and gating for the triggered channel.
    always_comb begin
        hi_int = intensity >= threshold;
        lo_chk = rec.cfg[BIT_LO_EN] | rec.cfg[BIT_BOTH_EN];
        hi_chk = rec.cfg[BIT_HI_EN] | rec.cfg[BIT_BOTH_EN];
        lo_bad = lo_chk && (rec.cfg[BIT_LO_AS_UPPER] ? (!hi_int && sample > rec.lo)
                                                      : (sample < rec.lo));
        hi_bad = hi_chk && (rec.cfg[BIT_HI_AS_UPPER] ? (hi_int && sample > rec.hi)
                                                      : (sample > rec.hi));
        limit_bad = is_analog ? (lo_bad | hi_bad) : (sample[0] != rec.cfg[BIT_DIG_LEVEL]);
        gate_ok = (!rec.cfg[BIT_NEED_EXT_A] || ext_permit_a) &&
                  (!rec.cfg[BIT_NEED_EXT_B] || ext_permit_b) &&
                  (!rec.cfg[BIT_NEED_BEAM]  || beam_present);
        trip_now = in_range && rec.cfg[BIT_ACTIVE] && gate_ok && limit_bad;
    end

endmodule

// File: rtl/pc_permit_gen.sv
// Module: pc_permit_gen
// Drives the permit line: high only when configured and all presence
// inputs are up, and forced low for PULSE_LEN cycles after each trip.
module pc_permit_gen #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_event,
    input  logic configured,
    input  logic clocks_ok,
    output logic permit
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic [CNT_W-1:0] pulse_cnt;
    logic [CNT_W:0]   low_run;
    logic             ready;

    assign ready  = configured && clocks_ok;
    assign permit = ready && (pulse_cnt == '0);

    // Low-pulse counter: reload on every trip, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                pulse_cnt <= '0;
        else if (trip_event)       pulse_cnt <= CNT_W'(PULSE_LEN);
        else if (pulse_cnt != '0)  pulse_cnt <= pulse_cnt - 1'b1;
    end

    // Checker-side run length of permit-low cycles while ready.
    always_ff @(posedge clk) begin
        if (!rst_n)                  low_run <= '0;
        else if (trip_event)         low_run <= 1;
        else if (ready && !permit)   low_run <= low_run + 1'b1;
        else                         low_run <= '0;
    end

    assert_trip_drops_permit_R13: assert property (@(posedge clk) disable iff (!rst_n)
        trip_event |=> !permit);

    assert_pulse_bounded_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !permit) |-> (low_run <= (CNT_W+1)'(PULSE_LEN)));

endmodule

// File: rtl/pc_trip_eval.sv
// Module: pc_trip_eval (top)
// Process channel trip evaluator: configuration store, per-trigger trip
// evaluation registered to a one-cycle result, and permit generation.
// Assumes sample/intensity/gate inputs are valid in the trigger cycle.
module pc_trip_eval
    import pc_trip_pkg::*;
#(
    parameter int NUM_CH    = 96,
    parameter int ANALOG_CH = 64,
    parameter int NUM_INST  = 4,
    parameter int PULSE_LEN = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_enable,
    input  logic        wr_valid,
    input  logic [2:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [2:0]  rd_sel,
    output logic [15:0] rd_data,
    input  logic        trig_valid,
    input  logic [15:0] trig_ptr,
    input  logic [15:0] sample,
    input  logic [15:0] intensity,
    input  logic        ext_permit_a,
    input  logic        ext_permit_b,
    input  logic        beam_present,
    input  logic        tclk_ok,
    input  logic        bsync_ok,
    input  logic        mdat_ok,
    input  logic        heartbeat_ok,
    output logic        trip_valid,
    output logic        trip,
    output logic [15:0] trip_ptr,
    output logic        permit
);
    chan_rec_t   trig_rec;
    logic        trig_in_range, trig_is_analog, configured, trip_now, trip_event;
    logic [15:0] threshold;

    pc_cfg_store #(.NUM_CH(NUM_CH), .ANALOG_CH(ANALOG_CH), .NUM_INST(NUM_INST)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
        .wr_valid(wr_valid), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .trig_ptr(trig_ptr),
        .trig_rec(trig_rec), .trig_in_range(trig_in_range),
        .trig_is_analog(trig_is_analog), .threshold(threshold),
        .configured(configured)
    );

    pc_limit_eval u_eval (
        .rec(trig_rec), .in_range(trig_in_range), .is_analog(trig_is_analog),
        .sample(sample), .intensity(intensity), .threshold(threshold),
        .ext_permit_a(ext_permit_a), .ext_permit_b(ext_permit_b),
        .beam_present(beam_present), .trip_now(trip_now)
    );

    assign trip_event = trig_valid && trip_now;

    pc_permit_gen #(.PULSE_LEN(PULSE_LEN)) u_permit (
        .clk(clk), .rst_n(rst_n), .trip_event(trip_event),
        .configured(configured),
        .clocks_ok(tclk_ok && bsync_ok && mdat_ok && heartbeat_ok),
        .permit(permit)
    );

    // Register the per-trigger result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trip_valid <= 1'b0;
            trip       <= 1'b0;
            trip_ptr   <= '0;
        end else begin
            trip_valid <= trig_valid;
            trip       <= trip_event;
            if (trig_valid) trip_ptr <= trig_ptr;
        end
    end

    assert_result_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |=> (trip_valid && trip_ptr == $past(trig_ptr)));

    assert_trip_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> trip_valid);

    assert_masked_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && !trig_rec.cfg[BIT_ACTIVE]) |=> !trip);

    assert_beam_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_rec.cfg[BIT_NEED_BEAM] && !beam_present) |=> !trip);

    assert_presence_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tclk_ok && bsync_ok && mdat_ok && heartbeat_ok) |-> !permit);

    assert_unconfigured_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !configured |-> !permit);

endmodule

// File: tb/pc_trip_eval_test.sv
module pc_trip_eval_test;
    import pc_trip_pkg::*;

    localparam int NCH = 6, NANA = 4, NINST = 2, PLEN = 16;

    logic clk = 0, rst_n = 0, cfg_enable = 0, wr_valid = 0, trig_valid = 0;
    logic [2:0]  wr_sel = 0, rd_sel = 0;
    logic [15:0] wr_data = 0, trig_ptr = 0, sample = 0, intensity = 0;
    logic ext_permit_a = 1, ext_permit_b = 1, beam_present = 1;
    logic tclk_ok = 1, bsync_ok = 1, mdat_ok = 1, heartbeat_ok = 1;
    logic [15:0] rd_data, trip_ptr;
    logic trip_valid, trip, permit;
    int n_tests = 0, n_fail = 0;
    bit done = 0;
    int smp [5] = '{99, 100, 150, 200, 201};

    pc_trip_eval #(.NUM_CH(NCH), .ANALOG_CH(NANA), .NUM_INST(NINST), .PULSE_LEN(PLEN)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .wr_valid(wr_valid),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .trig_valid(trig_valid), .trig_ptr(trig_ptr), .sample(sample),
        .intensity(intensity), .ext_permit_a(ext_permit_a), .ext_permit_b(ext_permit_b),
        .beam_present(beam_present), .tclk_ok(tclk_ok), .bsync_ok(bsync_ok),
        .mdat_ok(mdat_ok), .heartbeat_ok(heartbeat_ok), .trip_valid(trip_valid),
        .trip(trip), .trip_ptr(trip_ptr), .permit(permit)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk); wr_valid = 1; wr_sel = s; wr_data = d;
        @(negedge clk); wr_valid = 0;
    endtask

    task automatic rd_chk(input logic [2:0] s, input logic [15:0] exp, input string req);
        rd_sel = s; #1;
        check(rd_data === exp, req, {16'd0, rd_data}, {16'd0, exp});
    endtask

    task automatic fire(input logic [15:0] p, input logic [15:0] s, input logic exp, input string req);
        @(negedge clk); trig_valid = 1; trig_ptr = p; sample = s;
        @(negedge clk); trig_valid = 0;
        check({trip_valid, trip, trip_ptr} === {1'b1, exp, p}, req,
              {14'd0, trip_valid, trip, trip_ptr}, {14'd0, 1'b1, exp, p});
    endtask

    function automatic bit model_analog(input logic [15:0] c, input int lo, input int hi,
                                        input int s, input int inten, input int thr);
        bit hiint = inten >= thr;
        bit lchk = c[7] | c[5];
        bit hchk = c[6] | c[5];
        bit lb = lchk && (c[4] ? (!hiint && s > lo) : (s < lo));
        bit hb = hchk && (c[3] ? (hiint && s > hi) : (s > hi));
        return lb | hb;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check(permit === 1'b0, "R1 permit", {31'd0, permit}, 0);
        check(trip_valid === 1'b0 && trip === 1'b0, "R1 trip", {30'd0, trip_valid, trip}, 0);
        for (int s = 0; s < 6; s++) rd_chk(3'(s), 16'd0, "R1 readback");

        // R3: locked writes ignored; R2: pointer always writable
        wr(SEL_CONFIG, 16'h8000); wr(SEL_LO_LIM, 16'd77); wr(SEL_HI_LIM, 16'd88);
        wr(SEL_COUNT, 16'd1); wr(SEL_THRESH, 16'd55);
        rd_chk(SEL_CONFIG, 0, "R3 config"); rd_chk(SEL_LO_LIM, 0, "R3 lo");
        rd_chk(SEL_HI_LIM, 0, "R3 hi"); rd_chk(SEL_COUNT, 0, "R3 count");
        rd_chk(SEL_THRESH, 0, "R3 thresh");
        wr(SEL_POINTER, 16'h0102);
        rd_chk(SEL_POINTER, 16'h0102, "R2 pointer while locked");

        // R4: count range
        cfg_enable = 1;
        wr(SEL_COUNT, 16'd0);  rd_chk(SEL_COUNT, 0, "R4 zero refused");
        wr(SEL_COUNT, 16'd13); rd_chk(SEL_COUNT, 0, "R4 above max refused");
        wr(SEL_COUNT, 16'd12); rd_chk(SEL_COUNT, 12, "R4 max accepted");
        wr(SEL_COUNT, 16'd3);  rd_chk(SEL_COUNT, 3, "R4 mid accepted");

        // R5: permit follows config write count (refused write earlier not counted)
        for (int i = 0; i < 3; i++) begin
            check(permit === 1'b0, "R5 permit before enough configs", {31'd0, permit}, 0);
            wr(SEL_POINTER, 16'(i)); wr(SEL_CONFIG, 16'h0000);
        end
        #1 check(permit === 1'b1, "R5 permit after configs", {31'd0, permit}, 1);

        // R6: each presence input
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            tclk_ok = (k != 0); bsync_ok = (k != 1); mdat_ok = (k != 2); heartbeat_ok = (k != 3);
            #1 check(permit === 1'b0, "R6 presence low", {31'd0, permit}, 0);
            tclk_ok = 1; bsync_ok = 1; mdat_ok = 1; heartbeat_ok = 1;
            #1 check(permit === 1'b1, "R6 presence restored", {31'd0, permit}, 1);
        end

        // R11/R12: analog mode sweep on channel 0, instance 0
        wr(SEL_THRESH, 16'd1000);
        wr(SEL_POINTER, 16'h0000); wr(SEL_LO_LIM, 16'd100); wr(SEL_HI_LIM, 16'd200);
        rd_chk(SEL_LO_LIM, 100, "R2 lo readback"); rd_chk(SEL_HI_LIM, 200, "R2 hi readback");
        for (int m = 0; m < 32; m++) begin
            logic [15:0] c;
            c = 16'h8000 | 16'(m << 3);
            wr(SEL_CONFIG, c);
            for (int si = 0; si < 5; si++) begin
                for (int ii = 0; ii < 2; ii++) begin
                    intensity = (ii == 0) ? 16'd999 : 16'd1000;
                    fire(16'h0000, 16'(smp[si]),
                         model_analog(c, 100, 200, smp[si], int'(intensity), 1000),
                         (m[1:0] == 2'b00) ? "R11 analog limits" : "R12 intensity modes");
                end
            end
        end

        // R10: digital channels 4 and 5
        for (int ch = 4; ch < 6; ch++) begin
            for (int lv = 0; lv < 2; lv++) begin
                wr(SEL_POINTER, 16'(ch)); wr(SEL_CONFIG, 16'h8000 | 16'(lv << 8));
                for (int s = 0; s < 2; s++)
                    fire(16'(ch), 16'(s) | 16'h0100, s != lv, "R10 digital level");
            end
        end

        // R9: gating sweep on digital channel 4 (level 0, sample 1 mismatches)
        for (int g = 0; g < 8; g++) begin
            wr(SEL_POINTER, 16'd4); wr(SEL_CONFIG, 16'h8000 | 16'(g << 9));
            for (int in = 0; in < 8; in++) begin
                beam_present = in[0]; ext_permit_b = in[1]; ext_permit_a = in[2];
                fire(16'd4, 16'd1,
                     (!g[2] || in[2]) && (!g[1] || in[1]) && (!g[0] || in[0]), "R9 gating");
            end
        end
        ext_permit_a = 1; ext_permit_b = 1; beam_present = 1;

        // R8: masked channel and out-of-range pointers
        wr(SEL_POINTER, 16'd5); wr(SEL_CONFIG, 16'h0000);
        fire(16'd5, 16'd1, 0, "R8 masked channel");
        wr(SEL_POINTER, 16'h0006); wr(SEL_CONFIG, 16'h8000); wr(SEL_LO_LIM, 16'd9);
        rd_chk(SEL_CONFIG, 0, "R8 out-of-range config"); rd_chk(SEL_LO_LIM, 0, "R8 out-of-range lo");
        fire(16'h0006, 16'd1, 0, "R8 channel out of range");
        fire(16'h0204, 16'd1, 0, "R8 instance out of range");

        // R2: instances hold separate records
        wr(SEL_POINTER, 16'h0000); wr(SEL_CONFIG, 16'h8000);
        wr(SEL_POINTER, 16'h0100); wr(SEL_CONFIG, 16'h8080); wr(SEL_LO_LIM, 16'd500);
        rd_chk(SEL_CONFIG, 16'h8080, "R2 instance config");
        fire(16'h0100, 16'd300, 1, "R2 instance 1 trips");
        fire(16'h0000, 16'd300, 0, "R2 instance 0 separate");

        // R13: pulse length and restart
        repeat (20) @(negedge clk);
        check(permit === 1'b1, "R13 permit idle high", {31'd0, permit}, 1);
        fire(16'h0100, 16'd300, 1, "R13 trip");
        for (int k = 1; k <= PLEN; k++) begin
            if (k > 1) @(negedge clk);
            check(permit === 1'b0, "R13 pulse low", {31'd0, permit}, 0);
        end
        @(negedge clk);
        check(permit === 1'b1, "R13 pulse end", {31'd0, permit}, 1);
        fire(16'h0100, 16'd300, 1, "R13 trip again");
        repeat (9) @(negedge clk);
        fire(16'h0100, 16'd300, 1, "R13 retrigger");
        for (int k = 1; k <= PLEN; k++) begin
            if (k > 1) @(negedge clk);
            check(permit === 1'b0, "R13 restarted pulse low", {31'd0, permit}, 0);
        end
        @(negedge clk);
        check(permit === 1'b1, "R13 restarted pulse end", {31'd0, permit}, 1);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule